// File: doc/BRIEF.md
# Boundary-Splitting Region List Generator

This block turns one transfer request into a list of memory-region entries for a scatter/gather DMA engine. A request is a start byte address and a total byte length. The block cuts the transfer wherever it crosses a 64 KB-aligned boundary, so that no single entry spans two 64 KB pages. It writes the entries, one per clock, to a simple write port of a descriptor memory.

Each entry is a pair of 32-bit words. The first is the region address. The second is a count word: bits 15:0 hold the byte length, bit 31 marks the final entry of the list, and all other bits are zero. A region of exactly 65536 bytes has bits 15:0 equal to zero. A requester pulses `start_i` with the address and length present. The block answers with a one-cycle `done_o`, with `err_o` valid in that same cycle, and leaves the number of entries written on `entry_total_o`.

The controller is a state machine with four states:
- ST_IDLE waits for a start.
- ST_CHECK validates the request.
- ST_EMIT writes one entry per cycle.
- ST_FINISH raises done.

It has these transitions:
- IDLE→CHECK on `start_i`.
- CHECK→EMIT when the request is valid.
- CHECK→FINISH when the request is rejected.
- EMIT→EMIT while bytes remain beyond the current entry.
- EMIT→FINISH on the last entry.
- FINISH→IDLE always.

Top module: `region_list_gen`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o` and `wr_en_o` are 0 and `entry_total_o` is 0.
- R2: Entry 0 has the request address. Its length is the smaller of the request length and 65536 minus the address's low 16 bits.
- R3: Every later entry's address equals the previous entry's address with the low 16 bits cleared, plus 0x10000.
- R4: An entry covering a whole 64 KB page is written with count bits 15:0 equal to 0.
- R5: A leftover of 1 to 65535 bytes after the earlier entries produces one final, shorter entry carrying that length.
- R6: Count bit 31 is 1 on the final entry only, and count bits 30:16 are always 0.
- R7: A length above 262144 bytes is rejected: `done_o` and `err_o` are 1 together, no entry is written, and `entry_total_o` is 0.
- R8: An odd address (bit 0 = 1) or an odd length (bit 0 = 1) is rejected in the same way as R7.
- R9: A length of zero is rejected in the same way as R7.
- R10: Entries are written on consecutive cycles with `wr_idx_o` counting from 0. `done_o` is high for exactly one cycle, in the cycle right after the last write. `entry_total_o` then equals the number of entries written.
- R11: A `start_i` pulse that arrives while `busy_o` is 1 is ignored. The running list is unchanged, and no second done follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a build; sampled only when idle |
| base_addr_i | input | 32 | Start byte address of the transfer |
| byte_len_i | input | 32 | Total byte length of the transfer |
| busy_o | output | 1 | A build is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Request rejected; valid while `done_o` is 1 |
| wr_en_o | output | 1 | Entry write strobe |
| wr_idx_o | output | 3 | Entry index within the list |
| wr_addr_o | output | 32 | Entry region address |
| wr_cnt_o | output | 32 | Entry count word (end flag in bit 31, length in bits 15:0) |
| entry_total_o | output | 3 | Number of entries written by the last build |

## Verification
The hardest case to reach is a request with the largest legal length whose start is not 64 KB-aligned. Only this case fills all five index slots. It also has both a partial first entry and a partial final entry, with full zero-coded pages between them. The stimulus reaches it with a misaligned start and a length of exactly 262144 bytes. An aligned maximum request is also sent, so that the final entry is a full page whose length field is 0 while bit 31 is set. A second start is injected in the middle of a long emission to show that it cannot disturb the list.

// File: rtl/rlg_pkg.sv
package rlg_pkg;

    localparam int WORD_W  = 32;
    localparam int END_BIT = 31;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_EMIT,
        ST_FINISH
    } rlg_state_e;

endpackage

// File: rtl/rlg_check.sv
module rlg_check #(
    parameter int CNT_W     = 32,
    parameter int MAX_BYTES = 262144
) (
    input  logic             addr_lsb,
    input  logic [CNT_W-1:0] len,
    output logic             ok
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_BYTES);

    logic len_zero;
    logic len_big;
    logic odd_any;

    always_comb begin
        len_zero = (len == '0);
        len_big  = (len > LIMIT);
        odd_any  = addr_lsb | len[0];
        ok       = !(len_zero || len_big || odd_any);
    end
endmodule

// File: rtl/rlg_slice.sv
module rlg_slice #(
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 32,
    parameter int SEG_BITS = 16
) (
    input  logic [ADDR_W-1:0]          cur_addr,
    input  logic [CNT_W-1:0]           remain,
    output logic [CNT_W-1:0]           len,
    output logic                       is_last,
    output logic [rlg_pkg::WORD_W-1:0] cnt_word,
    output logic [ADDR_W-1:0]          next_addr
);
    import rlg_pkg::*;

    localparam logic [SEG_BITS:0] PAGE = {1'b1, {SEG_BITS{1'b0}}};

    logic [SEG_BITS:0] to_edge;
    logic [CNT_W-1:0]  to_edge_w;

    always_comb begin
        // bytes left before the next page edge
        to_edge   = PAGE - {1'b0, cur_addr[SEG_BITS-1:0]};
        to_edge_w = CNT_W'(to_edge);
        is_last   = (remain <= to_edge_w);
        len       = is_last ? remain : to_edge_w;

        // count word: length field low, end flag on top, rest zero
        cnt_word                 = '0;
        cnt_word[SEG_BITS-1:0]   = len[SEG_BITS-1:0];
        cnt_word[END_BIT]        = is_last;

        next_addr = {cur_addr[ADDR_W-1:SEG_BITS] + 1'b1, {SEG_BITS{1'b0}}};
    end
endmodule

// File: rtl/region_list_gen.sv
module region_list_gen #(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 32,
    parameter int SEG_BITS  = 16,
    parameter int MAX_BYTES = 262144,
    parameter int MAX_ENT   = (MAX_BYTES >> SEG_BITS) + 1,
    parameter int IDX_W     = $clog2(MAX_ENT + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [ADDR_W-1:0]          base_addr_i,
    input  logic [CNT_W-1:0]           byte_len_i,
    output logic                       busy_o,
    output logic                       done_o,
    output logic                       err_o,
    output logic                       wr_en_o,
    output logic [IDX_W-1:0]           wr_idx_o,
    output logic [ADDR_W-1:0]          wr_addr_o,
    output logic [rlg_pkg::WORD_W-1:0] wr_cnt_o,
    output logic [IDX_W-1:0]           entry_total_o
);
    import rlg_pkg::*;

    rlg_state_e state_q, state_d;

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  remain_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  total_q;
    logic              err_q;

    logic              req_ok;
    logic [CNT_W-1:0]  slice_len;
    logic              slice_last;
    logic [WORD_W-1:0] slice_word;
    logic [ADDR_W-1:0] slice_next;

    rlg_check #(
        .CNT_W     (CNT_W),
        .MAX_BYTES (MAX_BYTES)
    ) u_check (
        .addr_lsb (addr_q[0]),
        .len      (remain_q),
        .ok       (req_ok)
    );

    rlg_slice #(
        .ADDR_W   (ADDR_W),
        .CNT_W    (CNT_W),
        .SEG_BITS (SEG_BITS)
    ) u_slice (
        .cur_addr  (addr_q),
        .remain    (remain_q),
        .len       (slice_len),
        .is_last   (slice_last),
        .cnt_word  (slice_word),
        .next_addr (slice_next)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_CHECK;
            ST_CHECK:  state_d = req_ok ? ST_EMIT : ST_FINISH;
            ST_EMIT:   if (slice_last) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            remain_q <= '0;
            idx_q    <= '0;
            total_q  <= '0;
            err_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        addr_q   <= base_addr_i;
                        remain_q <= byte_len_i;
                        idx_q    <= '0;
                        total_q  <= '0;
                        err_q    <= 1'b0;
                    end
                end
                ST_CHECK: err_q <= !req_ok;
                ST_EMIT: begin
                    addr_q   <= slice_next;
                    remain_q <= remain_q - slice_len;
                    idx_q    <= idx_q + 1'b1;
                    total_q  <= idx_q + 1'b1;
                end
                ST_FINISH: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy_o        = (state_q != ST_IDLE);
        wr_en_o       = (state_q == ST_EMIT);
        done_o        = (state_q == ST_FINISH);
        err_o         = (state_q == ST_FINISH) && err_q;
        wr_idx_o      = idx_q;
        wr_addr_o     = addr_q;
        wr_cnt_o      = slice_word;
        entry_total_o = total_q;
    end

    // guards
    p_cnt_mid_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (wr_cnt_o[END_BIT-1:SEG_BITS] == '0));

    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && $past(wr_en_o)) |->
        (wr_addr_o == {$past(wr_addr_o[ADDR_W-1:SEG_BITS]) + 1'b1, {SEG_BITS{1'b0}}}));

    p_idx_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && $past(wr_en_o)) |-> (wr_idx_o == $past(wr_idx_o) + 1'b1));

    p_done_after_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && wr_cnt_o[END_BIT]) |=> (done_o && !wr_en_o));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_reject_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> (!$past(wr_en_o) && entry_total_o == '0));

    p_no_idle_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !wr_en_o);

endmodule

// File: tb/region_list_gen_tb_top.sv
`timescale 1ns/1ps
module region_list_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] base_addr_i = '0;
    logic [31:0] byte_len_i = '0;
    logic        busy_o, done_o, err_o, wr_en_o;
    logic [2:0]  wr_idx_o, entry_total_o;
    logic [31:0] wr_addr_o, wr_cnt_o;

    always #2 clk = ~clk;

    region_list_gen dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .base_addr_i   (base_addr_i),
        .byte_len_i    (byte_len_i),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .err_o         (err_o),
        .wr_en_o       (wr_en_o),
        .wr_idx_o      (wr_idx_o),
        .wr_addr_o     (wr_addr_o),
        .wr_cnt_o      (wr_cnt_o),
        .entry_total_o (entry_total_o)
    );

    typedef struct {
        int          idx;
        logic [31:0] addr;
        logic [31:0] word;
        bit          last;
        bit          full;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad = 0;
    int   cyc = 0;
    int   last_wr_cyc = -10;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            if (cyc > 60000) begin
                check(1'b0, "R10", "watchdog expired", cyc, 60000);
                finish_run();
            end
        end
    end

    // monitor: pop and compare each written entry
    always @(negedge clk) begin
        if (rst_n && wr_en_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10", "unexpected write", wr_addr_o, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(wr_idx_o == e.idx[2:0], "R10", "entry index", 32'(wr_idx_o), e.idx);
                if (e.idx != 0)
                    check(cyc == last_wr_cyc + 1, "R10", "writes not back to back", cyc, last_wr_cyc + 1);
                // address: R2 for entry 0, R3 for later entries
                check(wr_addr_o == e.addr, (e.idx == 0) ? "R2" : "R3", "entry address", wr_addr_o, e.addr);
                // count word: R5 remainder, R4 full page, R6 end flag and zero middle bits
                check(wr_cnt_o == e.word,
                      e.last && !e.full ? "R5" : (e.full ? "R4" : "R6"),
                      "count word", wr_cnt_o, e.word);
                check(wr_cnt_o[31] == e.last, "R6", "end flag", 32'(wr_cnt_o[31]), 32'(e.last));
                last_wr_cyc = cyc;
            end
        end
    end

    // driver: builds the expected list from the requirements, then runs one request
    task automatic run_case(input logic [31:0] a, input logic [31:0] c,
                            input string tag, input bit poke_busy);
        bit          exp_err;
        int          n;
        logic [31:0] cur;
        logic [31:0] rem;
        exp_err = (c == 0) || (c > 32'd262144) || a[0] || c[0];
        n = 0;
        if (!exp_err) begin
            cur = a;
            rem = c;
            while (rem != 0) begin
                exp_t        e;
                logic [31:0] span;
                logic [31:0] ln;
                span   = 32'h10000 - {16'h0, cur[15:0]};
                ln     = (rem <= span) ? rem : span;
                e.idx  = n;
                e.addr = cur;
                e.last = (rem <= span);
                e.full = (ln == 32'h10000);
                e.word = {e.last, 15'h0, ln[15:0]};
                exp_q.push_back(e);
                rem = rem - ln;
                cur = {cur[31:16] + 16'h1, 16'h0};
                n++;
            end
        end
        @(negedge clk);
        base_addr_i = a;
        byte_len_i  = c;
        start_i     = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (poke_busy) begin
            @(negedge clk);
            @(negedge clk);
            base_addr_i = 32'h0000_0011;
            byte_len_i  = 32'h0000_0003;
            start_i     = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
        check(err_o == exp_err, tag, "error flag at done", 32'(err_o), 32'(exp_err));
        check(entry_total_o == n[2:0], (exp_err ? tag : "R10"), "entry total",
              32'(entry_total_o), n);
        check(exp_q.size() == 0, (exp_err ? tag : "R10"), "entries still pending",
              exp_q.size(), 0);
        if (!exp_err)
            check(cyc == last_wr_cyc + 1, "R10", "done not right after last write", cyc, last_wr_cyc + 1);
        exp_q.delete();
        @(negedge clk);
        check(done_o == 1'b0, "R10", "done longer than one cycle", 32'(done_o), 0);
        if (poke_busy) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                check(!done_o && !busy_o, "R11", "activity after ignored start",
                      {30'h0, busy_o, done_o}, 0);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy_o && !done_o && !err_o && !wr_en_o, "R1", "reset outputs",
              {28'h0, busy_o, done_o, err_o, wr_en_o}, 0);
        check(entry_total_o == 0, "R1", "reset entry total", 32'(entry_total_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_case(32'h0001_2340, 32'h0000_0100, "R2", 1'b0);
        run_case(32'h0000_FF00, 32'h0000_0300, "R5", 1'b0);
        run_case(32'h0003_0000, 32'h0004_0000, "R4", 1'b0);
        run_case(32'h1234_5678, 32'h0004_0000, "R3", 1'b0);
        run_case(32'h0002_0000, 32'h0001_0000, "R6", 1'b0);
        run_case(32'h7FFF_F000, 32'h0000_2000, "R5", 1'b0);
        run_case(32'h0000_0000, 32'h0000_0002, "R2", 1'b0);
        run_case(32'h0000_1000, 32'h0004_0002, "R7", 1'b0);
        run_case(32'h0000_1001, 32'h0000_0100, "R8", 1'b0);
        run_case(32'h0000_1000, 32'h0000_0101, "R8", 1'b0);
        run_case(32'h0000_1000, 32'h0000_0000, "R9", 1'b0);
        run_case(32'h0005_8000, 32'h0002_0000, "R11", 1'b1);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule